// File: doc/BRIEF.md
# Bus-Master Burst Throttle Controller

This block governs the ownership of a shared system bus by a bus master that moves data between a local FIFO and the bus. It decides when to ask for the bus, how many data beats to move once the grant arrives, how far apart the beat strobes sit, and when to give the bus back. A command loads a byte count and a start address. Each beat moves 1, 2 or 4 bytes, takes that many bytes off the count and steps the address.

A request is raised only when the FIFO can serve a whole programmed block. For a transfer toward the bus the FIFO must hold enough data. For a transfer from the bus it must have enough free space. In normal mode one ownership lasts at most one block. In hog mode the master keeps the bus until it runs out of work, data or space, or until it is told to yield. A yield request, either a higher-priority request or an external release condition, starts a preempt timer counted in units of four clocks. The bus is returned when that timer expires.

Top module: `burst_throttle`

## Requirements
- R1: The block size code `blk_code` selects the beats per ownership in normal mode: code k in 0..5 gives 2^k beats, and codes 6 and 7 both give 64 beats.
- R2: `bus_req` rises only when the available FIFO bytes are at least the threshold. The available bytes are the fill level `fifo_lvl` when `to_bus`=1 and the free space FIFO_BYTES-`fifo_lvl` when `to_bus`=0. The threshold is the smallest of three values: block beats times the beat width, the remaining count rounded down to whole beats, and FIFO_BYTES. No request is raised while `term_cnt` is high.
- R3: In normal mode, `bus_req` falls in the cycle after the strobe that completes the block.
- R4: In hog mode the block size is ignored. Ownership ends only in four cases: `term_cnt` rises, the FIFO cannot serve one more beat (fewer than one beat of data toward the bus, or of free space from the bus), the grant drops, or the preempt timer expires.
- R5: When `hi_pri_req` or `rel_req` is first sampled high during ownership, at clock edge N, `bus_req` falls right after edge N+4*`preempt_time`+1. Beats may continue until then.
- R6: `term_cnt` is high exactly when the remaining count is less than one beat width. The width code `beat_sz` is 0=1 byte, 1=2 bytes, 2 or 3=4 bytes. No strobe is issued while `term_cnt` is high.
- R7: `cmd_go` loads `cmd_len` and `cmd_addr`. Each strobe adds the beat width to `bus_addr`, or adds 0 when `addr_hold`=1.
- R8: `beat_stb` is a one-cycle pulse. Consecutive strobes are separated by at least 4 idle cycles, or at least 6 when `slow_gap`=1. During a burst the spacing is exactly 5 or 7 cycles.
- R9: `connected` is high exactly while the master owns the bus and `gnt` is high. When `gnt` drops, strobes stop at once and `bus_req` falls after the next edge.
- R10: After reset: `bus_req`=0, `beat_stb`=0, `connected`=0, `term_cnt`=1, `done`=1. `done` is high when the controller is idle and `term_cnt` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_go | input | 1 | Load byte count and start address |
| cmd_len | input | CNT_W | Transfer length in bytes |
| cmd_addr | input | ADDR_W | Start address |
| to_bus | input | 1 | 1: FIFO data goes to the bus; 0: bus data fills the FIFO |
| beat_sz | input | 2 | Beat width code (0=1, 1=2, else 4 bytes) |
| blk_code | input | 3 | Block size code |
| hog_mode | input | 1 | Keep the bus past one block |
| preempt_time | input | PT_W | Yield delay in units of 4 clocks |
| addr_hold | input | 1 | Keep the address constant |
| slow_gap | input | 1 | 6 instead of 4 idle clocks between strobes |
| fifo_lvl | input | LVL_W | FIFO fill level in bytes |
| gnt | input | 1 | Bus grant |
| hi_pri_req | input | 1 | A higher-priority master wants the bus |
| rel_req | input | 1 | External release condition |
| bus_req | output | 1 | Bus request, held through ownership |
| beat_stb | output | 1 | One-cycle beat strobe |
| bus_addr | output | ADDR_W | Current beat address |
| connected | output | 1 | Owning the bus with grant present |
| term_cnt | output | 1 | Remaining count below one beat |
| done | output | 1 | Idle with nothing left to move |

## Verification
The bench uses the default parameters: a 128-byte FIFO, 24-bit count and address, and an 8-bit preempt field. The FIFO capacity equals the largest block at 2-byte beats, so code 6 and code 7 both reach the 64-beat cap within a single ownership. A table of eight vectors covers every block code region, all three beat widths, address hold, the slow gap and a count that ends mid-block. Directed cases then cover the fill and free-space thresholds, hog-mode stops on terminal count and on FIFO exhaustion, exact preempt timing for two timer values, and loss of grant.

// File: rtl/burst_throttle_pkg.sv
package burst_throttle_pkg;

  localparam int MAX_BEATS = 64;
  localparam int BEAT_W    = $clog2(MAX_BEATS + 1);

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_OWN  = 2'd2
  } bt_state_e;

  // width code to bytes per beat
  function automatic logic [2:0] beat_bytes(input logic [1:0] sz);
    case (sz)
      2'd0:    beat_bytes = 3'd1;
      2'd1:    beat_bytes = 3'd2;
      default: beat_bytes = 3'd4;
    endcase
  endfunction

  // block code to beats per ownership, saturating at MAX_BEATS
  function automatic logic [BEAT_W-1:0] block_beats(input logic [2:0] code);
    if (code >= 3'd6) block_beats = BEAT_W'(MAX_BEATS);
    else              block_beats = BEAT_W'(1) << code;
  endfunction

endpackage

// File: rtl/bt_threshold.sv
module bt_threshold
  import burst_throttle_pkg::*;
#(
  parameter int CNT_W      = 24,
  parameter int FIFO_BYTES = 128,
  parameter int LVL_W      = $clog2(FIFO_BYTES + 1)
) (
  input  logic [2:0]       blk_code,
  input  logic [2:0]       nbytes,
  input  logic [CNT_W-1:0] remain,
  input  logic [LVL_W-1:0] fifo_lvl,
  input  logic             to_bus,
  output logic             thr_met,
  output logic             fifo_ok,
  output logic             tc
);

  localparam logic [CNT_W-1:0] CAP = CNT_W'(FIFO_BYTES);

  logic [CNT_W-1:0] blk_b, rem_whole, thr_a, thr, lvl_c, avail, width_c;

  always_comb begin
    width_c   = CNT_W'(nbytes);
    blk_b     = CNT_W'(block_beats(blk_code)) * width_c;
    rem_whole = remain & ~(width_c - CNT_W'(1));
    thr_a     = (blk_b < rem_whole) ? blk_b : rem_whole;
    thr       = (thr_a < CAP) ? thr_a : CAP;
    lvl_c     = CNT_W'(fifo_lvl);
    if (to_bus)          avail = lvl_c;
    else if (lvl_c >= CAP) avail = '0;
    else                 avail = CAP - lvl_c;
    tc      = remain < width_c;
    fifo_ok = avail >= width_c;
    thr_met = !tc && (avail >= thr);
  end

endmodule

// File: rtl/bt_gap_timer.sv
module bt_gap_timer #(
  parameter int NORM_GAP = 4,
  parameter int SLOW_GAP = 6,
  localparam int GAP_W   = $clog2(SLOW_GAP + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic stb,
  input  logic slow,
  output logic ready
);

  logic [GAP_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = stb || (cnt_q != '0);
    if (stb)       cnt_d = slow ? GAP_W'(SLOW_GAP) : GAP_W'(NORM_GAP);
    else           cnt_d = cnt_q - GAP_W'(1);
    ready = (cnt_q == '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

endmodule

// File: rtl/bt_preempt.sv
module bt_preempt #(
  parameter int PT_W = 8,
  localparam int TC_W = PT_W + 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            own,
  input  logic            trig,
  input  logic [PT_W-1:0] ptime,
  output logic            expired
);

  logic            armed_q, armed_d;
  logic [TC_W-1:0] cnt_q, cnt_d;

  always_comb begin
    armed_d = armed_q;
    cnt_d   = cnt_q;
    if (!own) begin
      armed_d = 1'b0;
      cnt_d   = '0;
    end else if (!armed_q && trig) begin
      armed_d = 1'b1;
      cnt_d   = {ptime, 2'b00};
    end else if (armed_q && cnt_q != '0) begin
      cnt_d = cnt_q - TC_W'(1);
    end
    expired = armed_q && (cnt_q == '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      cnt_q   <= '0;
    end else begin
      armed_q <= armed_d;
      cnt_q   <= cnt_d;
    end
  end

endmodule

// File: rtl/burst_throttle.sv
module burst_throttle
  import burst_throttle_pkg::*;
#(
  parameter int CNT_W      = 24,
  parameter int ADDR_W     = 24,
  parameter int PT_W       = 8,
  parameter int FIFO_BYTES = 128,
  localparam int LVL_W     = $clog2(FIFO_BYTES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_go,
  input  logic [CNT_W-1:0]  cmd_len,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic              to_bus,
  input  logic [1:0]        beat_sz,
  input  logic [2:0]        blk_code,
  input  logic              hog_mode,
  input  logic [PT_W-1:0]   preempt_time,
  input  logic              addr_hold,
  input  logic              slow_gap,
  input  logic [LVL_W-1:0]  fifo_lvl,
  input  logic              gnt,
  input  logic              hi_pri_req,
  input  logic              rel_req,
  output logic              bus_req,
  output logic              beat_stb,
  output logic [ADDR_W-1:0] bus_addr,
  output logic              connected,
  output logic              term_cnt,
  output logic              done
);

  bt_state_e         state_q, state_d;
  logic [CNT_W-1:0]  rem_q, rem_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [BEAT_W-1:0] beats_q, beats_d;
  logic [2:0]        nbytes;
  logic              thr_met, fifo_ok, tc, gap_rdy, pre_exp;
  logic              own, last_blk, release_now;

  assign nbytes = beat_bytes(beat_sz);

  bt_threshold #(.CNT_W(CNT_W), .FIFO_BYTES(FIFO_BYTES)) u_thr (
    .blk_code (blk_code),
    .nbytes   (nbytes),
    .remain   (rem_q),
    .fifo_lvl (fifo_lvl),
    .to_bus   (to_bus),
    .thr_met  (thr_met),
    .fifo_ok  (fifo_ok),
    .tc       (tc)
  );

  bt_gap_timer u_gap (
    .clk   (clk),
    .rst_n (rst_n),
    .stb   (beat_stb),
    .slow  (slow_gap),
    .ready (gap_rdy)
  );

  bt_preempt #(.PT_W(PT_W)) u_pre (
    .clk     (clk),
    .rst_n   (rst_n),
    .own     (own),
    .trig    (hi_pri_req || rel_req),
    .ptime   (preempt_time),
    .expired (pre_exp)
  );

  // strobe and release decisions
  always_comb begin
    own         = (state_q == ST_OWN);
    beat_stb    = own && gnt && gap_rdy && !tc && fifo_ok && !pre_exp;
    last_blk    = !hog_mode && ((beats_q + BEAT_W'(1)) == block_beats(blk_code));
    release_now = own && (!gnt || tc || !fifo_ok || pre_exp || (beat_stb && last_blk));
  end

  // next state
  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE: if (thr_met) state_d = ST_REQ;
      ST_REQ: begin
        if (tc)       state_d = ST_IDLE;
        else if (gnt) state_d = ST_OWN;
      end
      ST_OWN:  if (release_now) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  // counters
  always_comb begin
    rem_d   = rem_q;
    addr_d  = addr_q;
    beats_d = beats_q;
    if (cmd_go) begin
      rem_d  = cmd_len;
      addr_d = cmd_addr;
    end else if (beat_stb) begin
      rem_d  = rem_q - CNT_W'(nbytes);
      addr_d = addr_q + (addr_hold ? '0 : ADDR_W'(nbytes));
    end
    if (!own)          beats_d = '0;
    else if (beat_stb) beats_d = beats_q + BEAT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      rem_q   <= '0;
      addr_q  <= '0;
      beats_q <= '0;
    end else begin
      state_q <= state_d;
      if (cmd_go || beat_stb) begin
        rem_q  <= rem_d;
        addr_q <= addr_d;
      end
      beats_q <= beats_d;
    end
  end

  assign bus_req   = (state_q != ST_IDLE);
  assign bus_addr  = addr_q;
  assign connected = own && gnt;
  assign term_cnt  = tc;
  assign done      = (state_q == ST_IDLE) && tc;

endmodule

// File: rtl/burst_throttle_chk.sv
module burst_throttle_chk
  import burst_throttle_pkg::*;
#(
  parameter int ADDR_W = 24
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_go,
  input logic [1:0]        beat_sz,
  input logic              addr_hold,
  input logic              slow_gap,
  input logic              gnt,
  input logic              bus_req,
  input logic              beat_stb,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              connected,
  input logic              term_cnt,
  input logic              done
);

  logic [3:0] idle_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              idle_cnt <= 4'hF;
    else if (beat_stb)       idle_cnt <= 4'd0;
    else if (idle_cnt != 4'hF) idle_cnt <= idle_cnt + 4'd1;
  end

  // R8
  stb_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    beat_stb |=> !beat_stb);

  // R8
  stb_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    beat_stb |-> (idle_cnt >= (slow_gap ? 4'd6 : 4'd4)));

  // R9
  stb_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    beat_stb |-> (gnt && connected));

  // R9
  conn_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    connected |-> bus_req);

  // R6
  stb_tc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    beat_stb |-> !term_cnt);

  // R7
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_stb && !cmd_go) |=>
      bus_addr == $past(bus_addr) + ADDR_W'($past(addr_hold) ? 3'd0 : beat_bytes($past(beat_sz))));

  // R10
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !bus_req);

endmodule

bind burst_throttle burst_throttle_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmd_go    (cmd_go),
  .beat_sz   (beat_sz),
  .addr_hold (addr_hold),
  .slow_gap  (slow_gap),
  .gnt       (gnt),
  .bus_req   (bus_req),
  .beat_stb  (beat_stb),
  .bus_addr  (bus_addr),
  .connected (connected),
  .term_cnt  (term_cnt),
  .done      (done)
);

// File: tb/tb_burst_throttle.sv
module tb_burst_throttle;

  localparam int CNT_W = 24, ADDR_W = 24, PT_W = 8, FIFO_BYTES = 128;
  localparam int LVL_W = $clog2(FIFO_BYTES + 1);

  logic clk = 1'b0, rst_n;
  logic cmd_go, to_bus, hog_mode, addr_hold, slow_gap, hi_pri_req, rel_req, gnt_en;
  logic [CNT_W-1:0]  cmd_len;
  logic [ADDR_W-1:0] cmd_addr;
  logic [1:0]        beat_sz;
  logic [2:0]        blk_code;
  logic [PT_W-1:0]   preempt_time;
  logic [LVL_W-1:0]  fifo_lvl;
  logic gnt, bus_req, beat_stb, connected, term_cnt, done;
  logic [ADDR_W-1:0] bus_addr;

  int errors = 0, checks = 0;
  bit finished = 0;

  always #4 clk = ~clk;
  assign gnt = gnt_en && bus_req;

  burst_throttle dut (
    .clk(clk), .rst_n(rst_n), .cmd_go(cmd_go), .cmd_len(cmd_len), .cmd_addr(cmd_addr),
    .to_bus(to_bus), .beat_sz(beat_sz), .blk_code(blk_code), .hog_mode(hog_mode),
    .preempt_time(preempt_time), .addr_hold(addr_hold), .slow_gap(slow_gap),
    .fifo_lvl(fifo_lvl), .gnt(gnt), .hi_pri_req(hi_pri_req), .rel_req(rel_req),
    .bus_req(bus_req), .beat_stb(beat_stb), .bus_addr(bus_addr), .connected(connected),
    .term_cnt(term_cnt), .done(done)
  );

  // code, size, hold, slow, length, beats, address delta, strobe spacing
  typedef struct packed {
    logic [2:0]  code;
    logic [1:0]  sz;
    logic        hold;
    logic        slow;
    logic [15:0] len;
    logic [7:0]  beats;
    logic [15:0] delta;
    logic [7:0]  spacing;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{3'd0, 2'd2, 1'b0, 1'b0, 16'd16,  8'd1,  16'd4,   8'd0},
    '{3'd1, 2'd1, 1'b0, 1'b0, 16'd16,  8'd2,  16'd4,   8'd5},
    '{3'd2, 2'd0, 1'b0, 1'b0, 16'd16,  8'd4,  16'd4,   8'd5},
    '{3'd3, 2'd2, 1'b0, 1'b1, 16'd64,  8'd8,  16'd32,  8'd7},
    '{3'd2, 2'd2, 1'b0, 1'b0, 16'd10,  8'd2,  16'd8,   8'd5},
    '{3'd1, 2'd0, 1'b1, 1'b0, 16'd5,   8'd2,  16'd0,   8'd5},
    '{3'd7, 2'd0, 1'b0, 1'b0, 16'd100, 8'd64, 16'd64,  8'd5},
    '{3'd6, 2'd1, 1'b0, 1'b0, 16'd200, 8'd64, 16'd128, 8'd5}
  };

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic start_cmd(input int len, input int addr);
    cmd_go = 1'b1; cmd_len = CNT_W'(len); cmd_addr = ADDR_W'(addr);
    @(negedge clk);
    cmd_go = 1'b0;
  endtask

  task automatic abort_cmd();
    start_cmd(0, 0);
    repeat (4) @(negedge clk);
  endtask

  task automatic wait_req();
    for (int i = 0; i < 50 && !bus_req; i++) @(negedge clk);
  endtask

  // counts strobes of one ownership; optional FIFO drain toward the bus
  task automatic run_own(input bit drain, output int n, output int spacing);
    int t = 0, prev = -1;
    n = 0; spacing = 0;
    wait_req();
    forever begin
      @(negedge clk);
      t++;
      if (beat_stb) begin
        n++;
        if (prev >= 0) spacing = t - prev;
        prev = t;
        if (drain) fifo_lvl = fifo_lvl - LVL_W'(4);
      end
      if (!bus_req || t > 3000) break;
    end
  endtask

  // returns negedges from raising the yield input until bus_req is low
  task automatic yield_delay(input bit use_hp, output int n);
    n = 0;
    if (use_hp) hi_pri_req = 1'b1; else rel_req = 1'b1;
    forever begin
      @(negedge clk);
      n++;
      hi_pri_req = 1'b0; rel_req = 1'b0;
      if (!bus_req || n > 2000) break;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int n, sp, hits;
    rst_n = 1'b0; cmd_go = 0; cmd_len = '0; cmd_addr = '0; to_bus = 1; beat_sz = 2;
    blk_code = 0; hog_mode = 0; preempt_time = '0; addr_hold = 0; slow_gap = 0;
    fifo_lvl = LVL_W'(FIFO_BYTES); hi_pri_req = 0; rel_req = 0; gnt_en = 1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R10 reset state
    chk("R10", "bus_req after reset", bus_req, 0);
    chk("R10", "beat_stb after reset", beat_stb, 0);
    chk("R10", "connected after reset", connected, 0);
    chk("R10", "term_cnt after reset", term_cnt, 1);
    chk("R10", "done after reset", done, 1);

    // R1 R3 R7 R8 vector table
    foreach (VECS[i]) begin
      blk_code = VECS[i].code; beat_sz = VECS[i].sz;
      addr_hold = VECS[i].hold; slow_gap = VECS[i].slow;
      start_cmd(int'(VECS[i].len), 'h1000);
      run_own(1'b0, n, sp);
      chk("R1/R3", $sformatf("vec%0d beats per ownership", i), n, VECS[i].beats);
      chk("R8", $sformatf("vec%0d strobe spacing", i), sp, VECS[i].spacing);
      chk("R7", $sformatf("vec%0d address delta", i), bus_addr - 'h1000, VECS[i].delta);
      abort_cmd();
    end
    addr_hold = 0; slow_gap = 0;

    // R2 fill threshold toward the bus: 4 beats x 4 bytes = 16
    gnt_en = 0; to_bus = 1; blk_code = 2; beat_sz = 2; fifo_lvl = 12;
    start_cmd(64, 0);
    hits = 0;
    for (int i = 0; i < 8; i++) begin @(negedge clk); if (bus_req) hits++; end
    chk("R2", "no request below fill threshold", hits, 0);
    fifo_lvl = 16;
    @(negedge clk);
    chk("R2", "request at fill threshold", bus_req, 1);
    abort_cmd();

    // R2 free space threshold from the bus
    to_bus = 0; fifo_lvl = 120;
    start_cmd(64, 0);
    hits = 0;
    for (int i = 0; i < 8; i++) begin @(negedge clk); if (bus_req) hits++; end
    chk("R2", "no request below free space threshold", hits, 0);
    fifo_lvl = 112;
    @(negedge clk);
    chk("R2", "request at free space threshold", bus_req, 1);
    abort_cmd();

    // R6 R2 count below one beat
    to_bus = 1; fifo_lvl = LVL_W'(FIFO_BYTES);
    start_cmd(3, 0);
    hits = 0;
    for (int i = 0; i < 8; i++) begin @(negedge clk); if (bus_req) hits++; end
    chk("R2", "no request with pseudo-zero count", hits, 0);
    chk("R6", "term_cnt with 3 bytes at 4-byte beats", term_cnt, 1);
    chk("R10", "done with pseudo-zero count", done, 1);
    gnt_en = 1;

    // R4 hog ends on terminal count
    hog_mode = 1; blk_code = 0; beat_sz = 2;
    start_cmd(40, 0);
    run_own(1'b0, n, sp);
    chk("R4", "hog beats until terminal count", n, 10);
    @(negedge clk);
    chk("R10", "done after hog transfer", done, 1);
    abort_cmd();

    // R4 hog ends when the FIFO runs dry
    fifo_lvl = 12;
    start_cmd(400, 0);
    run_own(1'b1, n, sp);
    chk("R4", "hog beats until FIFO empty", n, 3);
    hits = 0;
    for (int i = 0; i < 5; i++) begin @(negedge clk); if (bus_req) hits++; end
    chk("R2", "no request with empty FIFO", hits, 0);
    abort_cmd();
    fifo_lvl = LVL_W'(FIFO_BYTES);

    // R5 preempt in hog mode, T=2
    beat_sz = 0; preempt_time = 2;
    start_cmd(400, 0);
    wait_req();
    repeat (12) @(negedge clk);
    yield_delay(1'b1, n);
    chk("R5", "hog yield delay T=2", n, 4 * 2 + 2);
    abort_cmd();

    // R5 preempt with T=0
    preempt_time = 0;
    start_cmd(400, 0);
    wait_req();
    repeat (12) @(negedge clk);
    yield_delay(1'b1, n);
    chk("R5", "hog yield delay T=0", n, 2);
    abort_cmd();

    // R5 release condition in normal mode, T=1
    hog_mode = 0; blk_code = 7; preempt_time = 1;
    start_cmd(100, 0);
    wait_req();
    repeat (8) @(negedge clk);
    yield_delay(1'b0, n);
    chk("R5", "normal release-condition delay T=1", n, 6);
    abort_cmd();

    // R9 grant loss
    start_cmd(100, 0);
    for (int i = 0; i < 50 && !connected; i++) @(negedge clk);
    chk("R9", "connected while granted", connected, 1);
    repeat (3) @(negedge clk);
    gnt_en = 0;
    #1;
    chk("R9", "connected drops with grant", connected, 0);
    chk("R9", "no strobe without grant", beat_stb, 0);
    @(negedge clk);
    chk("R9", "bus_req after grant loss", bus_req, 0);
    abort_cmd();
    gnt_en = 1;

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule